// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Line Break and Pin Override

This block is a full-duplex asynchronous serial port. Both directions take their timing from a base tick that the surrounding logic supplies at sixteen times the bit rate. The receiver finds the start of a character on the oversampled line and reads every bit at its centre. It delivers one byte at a time and records overrun, parity and framing problems in flags that stay set. The transmitter holds one byte waiting in a data register. It serialises that byte only when the receive error flags are all clear.

The pin is not always driven by the transmitter. A function-select input can hand the TX pad to two plain port bits, one for level and one for drive enable. Software uses this to park the line at mark before transmission is enabled, or to force a break in the middle of a character. While the line is held low, the receiver keeps assembling all-zero frames. Each such frame sets the framing flag again, so software can tell that a break is still in progress.

Top module: `uart_brk_top`

## Requirements
- R1: A character is one 0 start bit, 8 data bits LSB first, then a parity bit when `par_en`=1, then one 1 stop bit. The parity bit makes the count of ones over data plus parity even when `par_odd`=0 and odd when `par_odd`=1. Every bit lasts 16 base ticks.
- R2: With nothing to send, the serial line sits at 1. A character starts once `tx_wr` has loaded `tx_data` and `tx_en`=1. `tx_empty` drops on the load and rises when the transmitter takes the byte.
- R3: The receiver passes `rx_pin` through two flops. The first base tick that sees the line low begins a character. The start bit is sampled on the 8th tick after that. If the sample reads 1, the character is dropped without a trace.
- R4: Each later bit is sampled 16 ticks after the previous sample. A finished byte appears on `rx_data` with `rx_full`=1, and `rx_rd` clears `rx_full`.
- R5: If a character finishes while `rx_full`=1, `err_ovr` sets, the new byte is thrown away, and `rx_data` keeps the unread byte.
- R6: A parity bit that breaks the selected rule sets `err_par`. The byte is still delivered.
- R7: A stop sample of 0 sets `err_frm`. A line held low keeps producing characters, so `err_frm` comes back one character after a clear.
- R8: Each error flag stays set until its own clear strobe. `clr_ovr`, `clr_par` and `clr_frm` each affect only their own flag, and dropping `rx_en` clears none of them.
- R9: While any error flag is set, a waiting byte is not started. The transmitter starts it once the flags are clear.
- R10: With `tx_fn_en`=0, `tx_pin` follows `pin_lvl` and `tx_oe` follows `pin_drv` one clock later, whatever the transmitter is doing. With `tx_fn_en`=1, `tx_oe`=1 and `tx_pin` carries the serial line.
- R11: Reset gives `tx_pin`=1, `tx_oe`=0, `rx_full`=0, all error flags 0, `tx_empty`=1 and `tx_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Base tick, 16 per bit |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_pin | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Unread byte waiting |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| err_ovr | output | 1 | Overrun flag |
| err_par | output | 1 | Parity error flag |
| err_frm | output | 1 | Framing error flag |
| clr_ovr | input | 1 | Clear strobe for err_ovr |
| clr_par | input | 1 | Clear strobe for err_par |
| clr_frm | input | 1 | Clear strobe for err_frm |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Load strobe for tx_data |
| tx_empty | output | 1 | Transmit data register empty |
| tx_busy | output | 1 | Character being shifted out |
| tx_fn_en | input | 1 | 1 = serial function owns the pad |
| pin_lvl | input | 1 | Port level used when overridden |
| pin_drv | input | 1 | Port drive enable used when overridden |
| tx_pin | output | 1 | Registered TX pad level |
| tx_oe | output | 1 | Registered TX pad drive enable |

## Verification
Several properties are checked on every clock. The error flags never fall without their own strobe. An unread byte stays put while later characters arrive. A start bit that reads high at its centre sends the receiver back to idle. A set flag keeps an idle transmitter idle. The pad follows the port bits one clock later whenever the override is active. Other behaviour needs the bench's scenarios to show it: the exact bit order and parity over every byte value in a loopback sweep, the sampling position, the break that re-raises the framing flag after a clear, and a transmission held back by a flag and then released.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic ovr;
    logic par;
    logic frm;
  } err_flags_t;

endpackage

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rx_pin,
  input  logic          rx_rd,
  input  logic          clr_ovr,
  input  logic          clr_par,
  input  logic          clr_frm,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output err_flags_t    err
);

  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [BW-1:0] BLAST = BW'(DW - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st;
  logic [CW-1:0] ocnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic          pbad;
  logic          frame_end;

  // two-flop synchronizer, idle level is mark
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_pin};
  end
  assign rx_s = sync_q[1];

  assign frame_end = rx_en && tick && (st == RX_STOP) && (ocnt == LAST);

  // bit-level sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      ocnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
      pbad  <= 1'b0;
    end else if (!rx_en) begin
      st   <= RX_IDLE;
      ocnt <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          if (!rx_s) begin
            st   <= RX_START;
            ocnt <= '0;
          end
        end
        RX_START: begin
          if (ocnt == MID) begin
            ocnt <= '0;
            bcnt <= '0;
            pbad <= 1'b0;
            st   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (ocnt == LAST) begin
            ocnt  <= '0;
            shreg <= {rx_s, shreg[DW-1:1]};
            if (bcnt == BLAST) st <= par_en ? RX_PAR : RX_STOP;
            else               bcnt <= bcnt + 1'b1;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (ocnt == LAST) begin
            ocnt <= '0;
            pbad <= ((^shreg) ^ rx_s) != par_odd;
            st   <= RX_STOP;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (ocnt == LAST) begin
            ocnt <= '0;
            st   <= RX_IDLE;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // data holding register and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      err     <= '0;
    end else begin
      if (frame_end && !rx_full) begin
        rx_data <= shreg;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
      err.ovr <= (frame_end && rx_full) || (err.ovr && !clr_ovr);
      err.par <= (frame_end && pbad)    || (err.par && !clr_par);
      err.frm <= (frame_end && !rx_s)   || (err.frm && !clr_frm);
    end
  end

  a_r8_frm_sticky: assert property (@(posedge clk) disable iff (rst)
    (err.frm && !clr_frm) |=> err.frm);

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (err.ovr && !clr_ovr) |=> err.ovr);

  a_r5_keep_unread: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));

  a_r3_glitch_reject: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && tick && ocnt == MID && rx_s) |=> (st == RX_IDLE));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_wr,
  input  logic          err_any,
  output logic          tx_line,
  output logic          tx_busy,
  output logic          tx_empty
);

  localparam int FW  = DW + 3;
  localparam int CW  = $clog2(OSR);
  localparam int BIW = $clog2(FW + 1);
  localparam logic [CW-1:0]  LAST   = CW'(OSR - 1);
  localparam logic [BIW-1:0] N_PAR  = BIW'(FW - 1);
  localparam logic [BIW-1:0] N_NPAR = BIW'(FW - 2);

  logic [DW-1:0]  tdr;
  logic           tdr_full;
  logic [FW-1:0]  sr;
  logic [CW-1:0]  tcnt;
  logic [BIW-1:0] bidx;
  logic [BIW-1:0] nlast;
  logic           start_ok;

  assign start_ok = tick && !tx_busy && tx_en && tdr_full && !err_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      tdr      <= '0;
      tdr_full <= 1'b0;
      sr       <= '1;
      tcnt     <= '0;
      bidx     <= '0;
      nlast    <= '0;
      tx_busy  <= 1'b0;
    end else begin
      if (start_ok) begin
        sr       <= par_en ? {1'b1, (^tdr) ^ par_odd, tdr, 1'b0}
                           : {2'b11, tdr, 1'b0};
        nlast    <= par_en ? N_PAR : N_NPAR;
        tdr_full <= 1'b0;
        tx_busy  <= 1'b1;
        tcnt     <= '0;
        bidx     <= '0;
      end else if (tx_busy && tick) begin
        if (tcnt == LAST) begin
          tcnt <= '0;
          if (bidx == nlast) begin
            tx_busy <= 1'b0;
          end else begin
            bidx <= bidx + 1'b1;
            sr   <= {1'b1, sr[FW-1:1]};
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (tx_wr) begin
        tdr      <= tx_data;
        tdr_full <= 1'b1;
      end
    end
  end

  assign tx_line  = tx_busy ? sr[0] : 1'b1;
  assign tx_empty = !tdr_full;

  a_r9_err_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (err_any && !tx_busy) |=> !tx_busy);

  a_r1_start_bit_low: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !tx_line);

endmodule

// File: rtl/uart_brk_pinmux.sv
module uart_brk_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic fn_en,
  input  logic pin_lvl,
  input  logic pin_drv,
  input  logic tx_line,
  output logic tx_pin,
  output logic tx_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin <= 1'b1;
      tx_oe  <= 1'b0;
    end else if (fn_en) begin
      tx_pin <= tx_line;
      tx_oe  <= 1'b1;
    end else begin
      tx_pin <= pin_lvl;
      tx_oe  <= pin_drv;
    end
  end

  a_r10_port_override: assert property (@(posedge clk) disable iff (rst)
    !fn_en |=> (tx_pin == $past(pin_lvl) && tx_oe == $past(pin_drv)));

endmodule

// File: rtl/uart_brk_top.sv
module uart_brk_top
  import uart_brk_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rx_pin,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  input  logic          rx_rd,
  output logic          err_ovr,
  output logic          err_par,
  output logic          err_frm,
  input  logic          clr_ovr,
  input  logic          clr_par,
  input  logic          clr_frm,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_wr,
  output logic          tx_empty,
  output logic          tx_busy,
  input  logic          tx_fn_en,
  input  logic          pin_lvl,
  input  logic          pin_drv,
  output logic          tx_pin,
  output logic          tx_oe
);

  err_flags_t err;
  logic       tx_line;

  uart_brk_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick16), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .rx_pin(rx_pin), .rx_rd(rx_rd),
    .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
    .rx_data(rx_data), .rx_full(rx_full), .err(err)
  );

  uart_brk_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data), .tx_wr(tx_wr),
    .err_any(|err), .tx_line(tx_line), .tx_busy(tx_busy), .tx_empty(tx_empty)
  );

  uart_brk_pinmux u_pin (
    .clk(clk), .rst(rst), .fn_en(tx_fn_en), .pin_lvl(pin_lvl),
    .pin_drv(pin_drv), .tx_line(tx_line), .tx_pin(tx_pin), .tx_oe(tx_oe)
  );

  assign err_ovr = err.ovr;
  assign err_par = err.par;
  assign err_frm = err.frm;

endmodule

// File: tb/uart_brk_top_tb.sv
module uart_brk_top_tb;

  localparam int BITCLK = 32;  // 16 ticks, tick every second clock

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rx_en = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic rx_pin, rx_drv = 1'b1, loop = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, rx_rd = 1'b0;
  logic err_ovr, err_par, err_frm;
  logic clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_wr = 1'b0, tx_empty, tx_busy;
  logic tx_fn_en = 1'b0, pin_lvl = 1'b1, pin_drv = 1'b0;
  logic tx_pin, tx_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick16 <= 1'b0;
    else     tick16 <= ~tick16;
  end

  assign rx_pin = loop ? tx_pin : rx_drv;

  uart_brk_top u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .rx_pin(rx_pin), .rx_data(rx_data),
    .rx_full(rx_full), .rx_rd(rx_rd), .err_ovr(err_ovr), .err_par(err_par),
    .err_frm(err_frm), .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
    .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_busy(tx_busy),
    .tx_fn_en(tx_fn_en), .pin_lvl(pin_lvl), .pin_drv(pin_drv),
    .tx_pin(tx_pin), .tx_oe(tx_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; clocks(1); rx_rd = 1'b0;
  endtask

  task automatic clear_all();
    clr_ovr = 1'b1; clr_par = 1'b1; clr_frm = 1'b1; rx_rd = 1'b1;
    clocks(1);
    clr_ovr = 1'b0; clr_par = 1'b0; clr_frm = 1'b0; rx_rd = 1'b0;
  endtask

  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; clocks(1); tx_wr = 1'b0;
  endtask

  // drive one character on rx_drv, each bit BITCLK clocks long
  task automatic drive_frame(input logic [7:0] d, input bit pe, input bit po,
                             input bit badp, input bit stopv);
    rx_drv = 1'b0; clocks(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rx_drv = d[i]; clocks(BITCLK);
    end
    if (pe) begin
      rx_drv = (^d) ^ po ^ badp; clocks(BITCLK);
    end
    rx_drv = stopv; clocks(BITCLK);
    rx_drv = 1'b1; clocks(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [10:0] expf;
    clocks(4);
    rst = 1'b0;
    clocks(1);
    // R11 reset state
    check(tx_pin == 1'b1 && tx_oe == 1'b0, "R11 pad", {tx_pin, tx_oe}, 2'b10);
    check(!rx_full && !err_ovr && !err_par && !err_frm, "R11 rx",
          {rx_full, err_ovr, err_par, err_frm}, 0);
    check(tx_empty && !tx_busy, "R11 tx", {tx_empty, tx_busy}, 2'b10);

    // R10 mark before enabling the transmitter
    pin_lvl = 1'b1; pin_drv = 1'b1; clocks(2);
    check(tx_pin == 1'b1 && tx_oe == 1'b1, "R10 mark", {tx_pin, tx_oe}, 2'b11);
    tx_fn_en = 1'b1; rx_en = 1'b1; tx_en = 1'b1; clocks(2);
    check(tx_pin == 1'b1 && tx_oe == 1'b1, "R2 idle high", {tx_pin, tx_oe}, 2'b11);

    // R1 direct waveform, odd parity
    par_en = 1'b1; par_odd = 1'b1;
    write_tx(8'hA5);
    check(!tx_empty || tx_busy, "R2 load", {tx_empty, tx_busy}, 0);
    expf = {1'b1, (^8'hA5) ^ 1'b1, 8'hA5, 1'b0};
    while (tx_pin) clocks(1);
    clocks(BITCLK / 2);
    for (int k = 0; k < 11; k++) begin
      check(tx_pin == expf[k], "R1 bit", tx_pin, expf[k]);
      clocks(BITCLK);
    end
    clocks(BITCLK);
    check(!tx_busy && tx_empty && tx_pin, "R2 done", {tx_busy, tx_empty, tx_pin}, 3'b011);
    pulse_rd();

    // R1 R4 loopback sweep over every byte value
    loop = 1'b1;
    for (int b = 0; b < 256; b++) begin
      par_en  = (b % 3) != 0;
      par_odd = b[1];
      write_tx(8'(b));
      for (int w = 0; w < 2000 && !rx_full; w++) clocks(1);
      check(rx_full && rx_data == 8'(b) && !err_par && !err_frm && !err_ovr,
            "R1 R4 loopback", {err_ovr, err_par, err_frm, rx_full, rx_data}, {4'b0001, 8'(b)});
      pulse_rd();
    end
    while (tx_busy) clocks(1);
    clocks(BITCLK);
    loop = 1'b0;
    clear_all();

    // R3 glitch rejection, then a clean character
    par_en = 1'b0;
    rx_drv = 1'b0; clocks(6); rx_drv = 1'b1; clocks(60);
    check(!rx_full && !err_frm && !err_par, "R3 glitch", {rx_full, err_frm, err_par}, 0);
    drive_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b1);
    check(rx_full && rx_data == 8'h96, "R3 R4 after glitch", rx_data, 8'h96);
    pulse_rd();
    check(!rx_full, "R4 read clears", rx_full, 0);

    // R5 overrun
    drive_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    drive_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    check(err_ovr && rx_data == 8'h3C, "R5 overrun", {err_ovr, rx_data}, {1'b1, 8'h3C});
    clear_all();

    // R6 parity error, byte delivered
    par_en = 1'b1; par_odd = 1'b0;
    drive_frame(8'h5A, 1'b1, 1'b0, 1'b1, 1'b1);
    check(err_par && rx_full && rx_data == 8'h5A, "R6 parity",
          {err_par, rx_full, rx_data}, {2'b11, 8'h5A});
    pulse_rd();

    // R9 flag blocks transmission
    write_tx(8'h0F);
    clocks(100);
    check(!tx_busy && !tx_empty && tx_pin, "R9 held", {tx_busy, tx_empty, tx_pin}, 3'b001);
    clr_par = 1'b1; clocks(1); clr_par = 1'b0;
    clocks(6);
    check(tx_busy, "R9 released", tx_busy, 1);

    // R10 break forced during a character
    clocks(BITCLK * 2);
    pin_lvl = 1'b0; pin_drv = 1'b1; tx_fn_en = 1'b0;
    clocks(1);
    check(tx_pin == 1'b0 && tx_oe == 1'b1 && tx_busy, "R10 break",
          {tx_pin, tx_oe, tx_busy}, 3'b011);
    pin_drv = 1'b0; clocks(1);
    check(tx_oe == 1'b0, "R10 drive off", tx_oe, 0);
    while (tx_busy) clocks(1);
    pin_lvl = 1'b1; tx_fn_en = 1'b1; clocks(1);
    check(tx_oe == 1'b1 && tx_pin == 1'b1, "R10 restore", {tx_pin, tx_oe}, 2'b11);

    // R7 single framing error
    par_en = 1'b0;
    drive_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
    check(err_frm && !err_par, "R7 framing", {err_frm, err_par}, 2'b10);
    clear_all();

    // R7 R8 break with odd parity: all flags set
    par_en = 1'b1; par_odd = 1'b1;
    rx_drv = 1'b0;
    clocks(BITCLK * 11 + 40);
    check(err_frm && err_par, "R7 break", {err_frm, err_par}, 2'b11);
    clr_frm = 1'b1; clocks(1); clr_frm = 1'b0;
    check(!err_frm, "R8 clear frm", err_frm, 0);
    clocks(BITCLK * 11 + 20);
    check(err_frm, "R7 break reasserts", err_frm, 1);
    check(err_ovr, "R5 break overrun", err_ovr, 1);
    rx_en = 1'b0; rx_drv = 1'b1; clocks(BITCLK * 2);
    check(err_frm && err_par && err_ovr, "R8 rx_en off keeps",
          {err_ovr, err_par, err_frm}, 3'b111);
    rx_en = 1'b1; clocks(BITCLK * 2);
    clr_ovr = 1'b1; clocks(1); clr_ovr = 1'b0;
    check(!err_ovr && err_par && err_frm, "R8 own clear",
          {err_ovr, err_par, err_frm}, 3'b011);
    clr_par = 1'b1; clocks(1); clr_par = 1'b0;
    check(!err_par && err_frm, "R8 par clear", {err_par, err_frm}, 2'b01);
    clear_all();
    check(!err_frm && !rx_full, "R8 all clear", {err_frm, rx_full}, 0);

    finish_up();
  end

endmodule